// File: doc/BRIEF.md
# Byte-Lane Dual-Port Synchronous RAM

This block is a true dual-port memory with two independent ports, left and right, each running on its own clock and its own synchronous active-low reset. Either port can read or write any word at any time, and both ports may touch the same word in the same cycle. The data word is made of byte lanes, and each lane has its own active-low enable. Reads and writes can therefore use any subset of lanes.

Each port registers its address, data, lane enables and control inputs on its rising clock edge. A port takes part in an access only when its low-active select is low and its high-active select is high. A static per-port input chooses the read latency: flow-through data appears right after the capture edge, and pipelined data appears one edge later. The output enable and the sleep input act without a clock and switch the outputs off at once. Sleep also stops the port from taking any access.

The output pins are shown as a data word plus one valid flag per lane. A lane whose flag is low stands for a high-impedance byte.

Top module: `dual_port_byte_ram`

## Requirements
- R1: A port is selected only when `sel_lo_n` is 0 and `sel_hi` is 1 at the capture edge. With any other combination, the access writes nothing and all of that port's `rvalid` flags are 0 for the access.
- R2: A full-lane write (`rw`=0, `lane_en_n`=0x00) stores the whole word. A later full-lane read (`rw`=1) of that address returns it.
- R3: A write stores only the lanes whose `lane_en_n` bit is 0. Bit i of `lane_en_n` controls data bits [i*LANE_W +: LANE_W]. All other lanes of the word keep their old value.
- R4: On a selected read, `rvalid[i]` equals the inverse of `lane_en_n[i]` as captured for that access. A write access raises no `rvalid` flag.
- R5: With `pipe`=0, read data and flags appear right after the capture edge. With `pipe`=1 they appear after the following edge, and the flags are delayed in step with the data.
- R6: While `oe_n` is 1, every `rvalid` flag is 0 at once, with no clock edge needed.
- R7: While `sleep` is 1, every `rvalid` flag is 0 at once. Any access presented at an edge while `sleep` is 1 is ignored and writes nothing.
- R8: Every `rdata` lane whose `rvalid` flag is 0 reads as all zeros.
- R9: While reset is held low at an edge, that port's `rvalid` and `rdata` are 0 afterwards. The stored words are not cleared.
- R10: A word written through one port can be read through the other port. Both ports may read the same word at the same time, and both get the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_n_l | input | 1 | Left synchronous active-low reset |
| sel_lo_n_l | input | 1 | Left select, active low |
| sel_hi_l | input | 1 | Left select, active high |
| rw_l | input | 1 | Left access kind: 1 read, 0 write |
| lane_en_n_l | input | LANES | Left per-lane enables, active low |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | LANES*LANE_W | Left write data |
| oe_n_l | input | 1 | Left output enable, active low, no clock |
| sleep_l | input | 1 | Left sleep, active high, no clock |
| pipe_l | input | 1 | Left latency select: 1 pipelined, 0 flow-through |
| rdata_l | output | LANES*LANE_W | Left read data |
| rvalid_l | output | LANES | Left per-lane output valid |
| clk_r | input | 1 | Right port clock |
| rst_n_r | input | 1 | Right synchronous active-low reset |
| sel_lo_n_r | input | 1 | Right select, active low |
| sel_hi_r | input | 1 | Right select, active high |
| rw_r | input | 1 | Right access kind: 1 read, 0 write |
| lane_en_n_r | input | LANES | Right per-lane enables, active low |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | LANES*LANE_W | Right write data |
| oe_n_r | input | 1 | Right output enable, active low, no clock |
| sleep_r | input | 1 | Right sleep, active high, no clock |
| pipe_r | input | 1 | Right latency select: 1 pipelined, 0 flow-through |
| rdata_r | output | LANES*LANE_W | Right read data |
| rvalid_r | output | LANES | Right per-lane output valid |

## Verification
Several properties are checked on every clock edge:
- the output enable and sleep gating of the flags;
- zeroed data in unflagged lanes;
- the flags expected from the select, lane-enable and access-kind inputs captured one edge earlier (flow-through) or two edges earlier (pipelined);
- the cleared outputs after reset.

These properties say nothing about stored contents. Only the bench's scenarios can show the following:
- that masked lanes survive a partial write;
- that a write through one port is read back through the other;
- that a write presented during sleep or while deselected leaves the word untouched;
- that the flags come back after a short output-enable pulse.

// File: rtl/dpr_pkg.sv
// Package: shared types and default sizes for the dual-port byte-lane RAM.
// Assumes: all users import it before declaring ports that use its types.
package dpr_pkg;
    localparam int unsigned DPR_ADDR_W_DEF = 8;
    localparam int unsigned DPR_LANES_DEF  = 8;
    localparam int unsigned DPR_LANE_W_DEF = 9;

    // Kind of access latched at the capture edge.
    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_e;
endpackage

// File: rtl/dpr_port_ctrl.sv
// Port front end: registers address, data, lane enables and control on the
// port clock, and turns them into per-lane write strobes and read flags.
// Assumes: sleep is already settled at the edge; while asleep the access is
// dropped and the held address stays put, so the read path stays stable.
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int unsigned LANES  = DPR_LANES_DEF,
    parameter int unsigned LANE_W = DPR_LANE_W_DEF,
    parameter int unsigned ADDR_W = DPR_ADDR_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_lo_n,
    input  logic                    sel_hi,
    input  logic                    rw,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    sleep,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [LANES*LANE_W-1:0] wdata_q,
    output logic [LANES-1:0]        wr_lanes,
    output logic [LANES-1:0]        rd_lanes
);
    localparam int unsigned DW = LANES * LANE_W;

    logic             sel_q;
    acc_e             acc_q;
    logic [LANES-1:0] len_n_q;

    // Capture one access per edge; sleep or a bad select turns it into a no-op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            acc_q   <= ACC_READ;
            len_n_q <= '1;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            sel_q <= !sel_lo_n && sel_hi && !sleep;
            if (!sleep) begin
                acc_q   <= acc_e'(rw);
                len_n_q <= lane_en_n;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    // Decode the held access into lane strobes for the array and the reader.
    always_comb begin
        wr_lanes = '0;
        rd_lanes = '0;
        if (sel_q) begin
            if (acc_q == ACC_WRITE) wr_lanes = ~len_n_q;
            else                    rd_lanes = ~len_n_q;
        end
    end

    logic [DW-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/dpr_bank.sv
// One half of the XOR-coded storage: lane-split word arrays with one writer
// and two read ports. A stored word is the XOR of the same address in both
// halves, so each half has a single clock and a single writer.
// Assumes: the writer supplies data already coded against the other half.
module dpr_bank #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr0,
    input  logic [ADDR_W-1:0]       raddr1,
    output logic [LANES*LANE_W-1:0] rdata0,
    output logic [LANES*LANE_W-1:0] rdata1
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when its strobe is up.
        always_ff @(posedge clk) begin
            if (wr_lanes[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata0[g*LANE_W +: LANE_W] = mem[raddr0];
        assign rdata1[g*LANE_W +: LANE_W] = mem[raddr1];
    end
endmodule

// File: rtl/dpr_out_stage.sv
// Output stage of one port: an optional extra register for the pipelined
// latency, and gating by output enable and sleep without a clock.
// Assumes: pipe_en is static during traffic; unflagged lanes drive zero.
module dpr_out_stage #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_en,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] word_in,
    input  logic [LANES-1:0]        vld_in,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        rvalid
);
    localparam int unsigned DW = LANES * LANE_W;

    logic [DW-1:0]    word_p;
    logic [LANES-1:0] vld_p;
    logic [DW-1:0]    word_s;
    logic [LANES-1:0] vld_s;

    // Extra stage for pipelined reads; flags travel with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_p <= '0;
            vld_p  <= '0;
        end else begin
            word_p <= word_in;
            vld_p  <= vld_in;
        end
    end

    // Choose latency, then apply output enable and sleep.
    always_comb begin
        word_s = pipe_en ? word_p : word_in;
        vld_s  = pipe_en ? vld_p  : vld_in;
        rvalid = (oe_n || sleep) ? '0 : vld_s;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign rdata[g*LANE_W +: LANE_W] =
            rvalid[g] ? word_s[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/dual_port_byte_ram.sv
// Top: true dual-port byte-lane RAM with independent left and right clocks.
// Storage is two XOR-coded halves, one written per port. A write commits on
// the edge after capture, from the held registers.
// Assumes: simultaneous writes of one word by both ports leave it undefined.
module dual_port_byte_ram
    import dpr_pkg::*;
#(
    parameter int unsigned LANES  = DPR_LANES_DEF,
    parameter int unsigned LANE_W = DPR_LANE_W_DEF,
    parameter int unsigned ADDR_W = DPR_ADDR_W_DEF
) (
    input  logic                    clk_l,
    input  logic                    rst_n_l,
    input  logic                    sel_lo_n_l,
    input  logic                    sel_hi_l,
    input  logic                    rw_l,
    input  logic [LANES-1:0]        lane_en_n_l,
    input  logic [ADDR_W-1:0]       addr_l,
    input  logic [LANES*LANE_W-1:0] wdata_l,
    input  logic                    oe_n_l,
    input  logic                    sleep_l,
    input  logic                    pipe_l,
    output logic [LANES*LANE_W-1:0] rdata_l,
    output logic [LANES-1:0]        rvalid_l,
    input  logic                    clk_r,
    input  logic                    rst_n_r,
    input  logic                    sel_lo_n_r,
    input  logic                    sel_hi_r,
    input  logic                    rw_r,
    input  logic [LANES-1:0]        lane_en_n_r,
    input  logic [ADDR_W-1:0]       addr_r,
    input  logic [LANES*LANE_W-1:0] wdata_r,
    input  logic                    oe_n_r,
    input  logic                    sleep_r,
    input  logic                    pipe_r,
    output logic [LANES*LANE_W-1:0] rdata_r,
    output logic [LANES-1:0]        rvalid_r
);
    localparam int unsigned DW = LANES * LANE_W;

    logic [ADDR_W-1:0] aq_l, aq_r;
    logic [DW-1:0]     dq_l, dq_r;
    logic [LANES-1:0]  wr_l, wr_r, rd_l, rd_r;
    logic [DW-1:0]     bl_0, bl_1, br_0, br_1;
    logic [DW-1:0]     code_l, code_r;
    logic [DW-1:0]     word_l, word_r;

    dpr_port_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_ctrl_l (
        .clk(clk_l), .rst_n(rst_n_l), .sel_lo_n(sel_lo_n_l), .sel_hi(sel_hi_l),
        .rw(rw_l), .lane_en_n(lane_en_n_l), .addr(addr_l), .wdata(wdata_l),
        .sleep(sleep_l), .addr_q(aq_l), .wdata_q(dq_l),
        .wr_lanes(wr_l), .rd_lanes(rd_l)
    );

    dpr_port_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_ctrl_r (
        .clk(clk_r), .rst_n(rst_n_r), .sel_lo_n(sel_lo_n_r), .sel_hi(sel_hi_r),
        .rw(rw_r), .lane_en_n(lane_en_n_r), .addr(addr_r), .wdata(wdata_r),
        .sleep(sleep_r), .addr_q(aq_r), .wdata_q(dq_r),
        .wr_lanes(wr_r), .rd_lanes(rd_r)
    );

    // Code write data against the other half at the same address.
    assign code_l = dq_l ^ br_0;
    assign code_r = dq_r ^ bl_1;

    dpr_bank #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_bank_l (
        .clk(clk_l), .wr_lanes(wr_l), .waddr(aq_l), .wdata(code_l),
        .raddr0(aq_l), .raddr1(aq_r), .rdata0(bl_0), .rdata1(bl_1)
    );

    dpr_bank #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_bank_r (
        .clk(clk_r), .wr_lanes(wr_r), .waddr(aq_r), .wdata(code_r),
        .raddr0(aq_l), .raddr1(aq_r), .rdata0(br_0), .rdata1(br_1)
    );

    // Decode each port's word from both halves.
    assign word_l = bl_0 ^ br_0;
    assign word_r = bl_1 ^ br_1;

    dpr_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out_l (
        .clk(clk_l), .rst_n(rst_n_l), .pipe_en(pipe_l), .oe_n(oe_n_l),
        .sleep(sleep_l), .word_in(word_l), .vld_in(rd_l),
        .rdata(rdata_l), .rvalid(rvalid_l)
    );

    dpr_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out_r (
        .clk(clk_r), .rst_n(rst_n_r), .pipe_en(pipe_r), .oe_n(oe_n_r),
        .sleep(sleep_r), .word_in(word_r), .vld_in(rd_r),
        .rdata(rdata_r), .rvalid(rvalid_r)
    );
endmodule

// File: rtl/dpr_chk.sv
// Checker: port-level properties of the dual-port byte-lane RAM.
// Assumes: bound to every instance of the top; sees only its ports.
module dpr_chk #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned ADDR_W = 8
) (
    input logic                    clk_l,
    input logic                    rst_n_l,
    input logic                    sel_lo_n_l,
    input logic                    sel_hi_l,
    input logic                    rw_l,
    input logic [LANES-1:0]        lane_en_n_l,
    input logic [ADDR_W-1:0]       addr_l,
    input logic [LANES*LANE_W-1:0] wdata_l,
    input logic                    oe_n_l,
    input logic                    sleep_l,
    input logic                    pipe_l,
    input logic [LANES*LANE_W-1:0] rdata_l,
    input logic [LANES-1:0]        rvalid_l,
    input logic                    clk_r,
    input logic                    rst_n_r,
    input logic                    sel_lo_n_r,
    input logic                    sel_hi_r,
    input logic                    rw_r,
    input logic [LANES-1:0]        lane_en_n_r,
    input logic [ADDR_W-1:0]       addr_r,
    input logic [LANES*LANE_W-1:0] wdata_r,
    input logic                    oe_n_r,
    input logic                    sleep_r,
    input logic                    pipe_r,
    input logic [LANES*LANE_W-1:0] rdata_r,
    input logic [LANES-1:0]        rvalid_r
);
    function automatic logic [LANES*LANE_W-1:0] spread(input logic [LANES-1:0] v);
        for (int i = 0; i < LANES; i++) spread[i*LANE_W +: LANE_W] = {LANE_W{v[i]}};
    endfunction

    logic sel_rd_l;
    logic desel_l;
    assign sel_rd_l = !sel_lo_n_l && sel_hi_l && !sleep_l && rw_l;
    assign desel_l  = sel_lo_n_l || !sel_hi_l || sleep_l;

    // R6
    oe_off_l_chk: assert property (@(posedge clk_l) disable iff (!rst_n_l)
        oe_n_l |-> rvalid_l == '0);
    // R6
    oe_off_r_chk: assert property (@(posedge clk_r) disable iff (!rst_n_r)
        oe_n_r |-> rvalid_r == '0);
    // R7
    sleep_off_l_chk: assert property (@(posedge clk_l) disable iff (!rst_n_l)
        sleep_l |-> rvalid_l == '0);
    // R7
    sleep_off_r_chk: assert property (@(posedge clk_r) disable iff (!rst_n_r)
        sleep_r |-> rvalid_r == '0);
    // R8
    lane_zero_l_chk: assert property (@(posedge clk_l) disable iff (!rst_n_l)
        (rdata_l & ~spread(rvalid_l)) == '0);
    // R8
    lane_zero_r_chk: assert property (@(posedge clk_r) disable iff (!rst_n_r)
        (rdata_r & ~spread(rvalid_r)) == '0);
    // R1
    desel_flow_chk: assert property (@(posedge clk_l) disable iff (!rst_n_l)
        !pipe_l && $past(rst_n_l) && $past(desel_l) |-> rvalid_l == '0);
    // R4
    write_noflag_chk: assert property (@(posedge clk_l) disable iff (!rst_n_l)
        !pipe_l && $past(rst_n_l) && $past(!rw_l) |-> rvalid_l == '0);
    // R4
    read_lanes_flow_chk: assert property (@(posedge clk_l) disable iff (!rst_n_l)
        !pipe_l && !oe_n_l && !sleep_l && $past(rst_n_l) && $past(sel_rd_l)
        |-> rvalid_l == ~$past(lane_en_n_l));
    // R5
    read_lanes_pipe_chk: assert property (@(posedge clk_l) disable iff (!rst_n_l)
        pipe_l && !oe_n_l && !sleep_l && $past(rst_n_l) && $past(rst_n_l, 2)
        && $past(sel_rd_l, 2) |-> rvalid_l == ~$past(lane_en_n_l, 2));
    // R9
    reset_clear_chk: assert property (@(posedge clk_l)
        !rst_n_l |=> rvalid_l == '0);
endmodule

bind dual_port_byte_ram dpr_chk #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dual_port_byte_ram.sv
module sim_dual_port_byte_ram;
    localparam int LN = 8;
    localparam int LW = 9;
    localparam int AW = 8;
    localparam int DW = LN * LW;

    logic clk_l = 1'b0, clk_r = 1'b0;
    logic rst_n_l, rst_n_r;
    logic sel_lo_n_l, sel_hi_l, rw_l, oe_n_l, sleep_l, pipe_l;
    logic sel_lo_n_r, sel_hi_r, rw_r, oe_n_r, sleep_r, pipe_r;
    logic [LN-1:0] lane_en_n_l, lane_en_n_r, rvalid_l, rvalid_r;
    logic [AW-1:0] addr_l, addr_r;
    logic [DW-1:0] wdata_l, wdata_r, rdata_l, rdata_r;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] model [1<<AW];

    dual_port_byte_ram #(.LANES(LN), .LANE_W(LW), .ADDR_W(AW)) u0 (.*);

    always #4 clk_l = ~clk_l;
    initial begin #2; forever #4 clk_r = ~clk_r; end

    function automatic logic [DW-1:0] lmask(input logic [LN-1:0] v);
        for (int i = 0; i < LN; i++) lmask[i*LW +: LW] = {LW{v[i]}};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic edge_of(input bit side);
        if (side) @(posedge clk_r); else @(posedge clk_l);
    endtask

    task automatic set_in(input bit side, input logic lo_n, input logic hi, input logic rw,
                          input logic [LN-1:0] be, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (side) begin
            sel_lo_n_r = lo_n; sel_hi_r = hi; rw_r = rw; lane_en_n_r = be; addr_r = a; wdata_r = d;
        end else begin
            sel_lo_n_l = lo_n; sel_hi_l = hi; rw_l = rw; lane_en_n_l = be; addr_l = a; wdata_l = d;
        end
    endtask

    task automatic idle(input bit side);
        set_in(side, 1'b1, 1'b0, 1'b1, '1, '0, '0);
    endtask

    task automatic port_write(input bit side, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input logic [LN-1:0] be);
        set_in(side, 1'b0, 1'b1, 1'b0, be, a, d);
        edge_of(side); #1; idle(side);
        edge_of(side); #1;
        for (int i = 0; i < LN; i++)
            if (!be[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
    endtask

    task automatic port_read(input bit side, input logic [AW-1:0] a, input logic [LN-1:0] be,
                             output logic [DW-1:0] d, output logic [LN-1:0] v);
        set_in(side, 1'b0, 1'b1, 1'b1, be, a, '0);
        edge_of(side); #1; idle(side);
        if (side ? pipe_r : pipe_l) begin edge_of(side); #1; end
        d = side ? rdata_r : rdata_l;
        v = side ? rvalid_r : rvalid_l;
    endtask

    task automatic t_reset;
        chk("R9 left flags", {64'd0, rvalid_l}, '0);
        chk("R9 left data", rdata_l, '0);
        chk("R9 right flags", {64'd0, rvalid_r}, '0);
    endtask

    task automatic t_full;
        logic [DW-1:0] d; logic [LN-1:0] v;
        port_write(0, 8'h05, 72'h12_3456_789a_bcde_f012, 8'h00);
        port_write(0, 8'hff, 72'hfe_dcba_9876_5432_1011, 8'h00);
        port_read(0, 8'h05, 8'h00, d, v);
        chk("R2 read word 05", d, model[8'h05]);
        chk("R5 flow flags right after edge", {64'd0, v}, {64'd0, 8'hff});
        port_read(0, 8'hff, 8'h00, d, v);
        chk("R2 read word ff", d, model[8'hff]);
    endtask

    task automatic t_partial;
        logic [DW-1:0] d; logic [LN-1:0] v;
        port_write(0, 8'h10, {DW{1'b1}}, 8'h00);
        port_write(0, 8'h10, '0, 8'b1010_0101);
        port_read(0, 8'h10, 8'h00, d, v);
        chk("R3 masked lanes kept", d, model[8'h10]);
        chk("R3 exact merge", d, ~lmask(8'b0101_1010));
        port_read(0, 8'h10, 8'b1100_0011, d, v);
        chk("R4 flags follow lane enables", {64'd0, v}, {64'd0, 8'b0011_1100});
        chk("R8 unflagged lanes zero", d, model[8'h10] & lmask(8'b0011_1100));
    endtask

    task automatic t_cross;
        logic [DW-1:0] d, d2; logic [LN-1:0] v, v2;
        port_write(0, 8'h20, 72'h01_0203_0405_0607_0809, 8'h00);
        port_read(1, 8'h20, 8'h00, d, v);
        chk("R10 left write right read", d, model[8'h20]);
        port_write(1, 8'h21, 72'haa_bbcc_ddee_ff00_1122, 8'hf0);
        port_read(0, 8'h21, 8'hf0, d, v);
        chk("R10 right write left read", d, model[8'h21] & lmask(8'h0f));
        fork
            port_read(0, 8'h20, 8'h00, d, v);
            port_read(1, 8'h20, 8'h00, d2, v2);
        join
        chk("R10 same word both ports left", d, model[8'h20]);
        chk("R10 same word both ports right", d2, model[8'h20]);
    endtask

    task automatic t_pipe;
        logic [DW-1:0] d; logic [LN-1:0] v;
        edge_of(1); #1; pipe_r = 1'b1;
        edge_of(1); #1;
        set_in(1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h20, '0);
        edge_of(1); #1; idle(1);
        chk("R5 pipelined not yet valid", {64'd0, rvalid_r}, '0);
        edge_of(1); #1;
        chk("R5 pipelined data one edge later", rdata_r, model[8'h20]);
        chk("R5 pipelined flags aligned", {64'd0, rvalid_r}, {64'd0, 8'hff});
        port_read(1, 8'h21, 8'h3c, d, v);
        chk("R5 pipelined partial flags", {64'd0, v}, {64'd0, 8'hc3});
        pipe_r = 1'b0;
        edge_of(1); #1;
    endtask

    task automatic t_desel;
        logic [DW-1:0] d; logic [LN-1:0] v;
        set_in(0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h05, '0);
        edge_of(0); #1;
        chk("R1 low select high", {64'd0, rvalid_l}, '0);
        set_in(0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h05, '0);
        edge_of(0); #1;
        chk("R1 high select low", {64'd0, rvalid_l}, '0);
        set_in(0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05, 72'h0);
        edge_of(0); #1; idle(0); edge_of(0); #1;
        port_read(0, 8'h05, 8'h00, d, v);
        chk("R1 deselected write ignored", d, model[8'h05]);
    endtask

    task automatic t_oe_sleep;
        logic [DW-1:0] d; logic [LN-1:0] v;
        set_in(0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hff, '0);
        edge_of(0); #1;
        oe_n_l = 1'b1; #1;
        chk("R6 oe off flags", {64'd0, rvalid_l}, '0);
        chk("R6 oe off data", rdata_l, '0);
        oe_n_l = 1'b0; #1;
        chk("R6 oe back on", rdata_l, model[8'hff]);
        sleep_l = 1'b1; #1;
        chk("R7 sleep off flags", {64'd0, rvalid_l}, '0);
        set_in(0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hff, 72'h0);
        edge_of(0); #1; edge_of(0); #1;
        idle(0); sleep_l = 1'b0;
        edge_of(0); #1;
        port_read(0, 8'hff, 8'h00, d, v);
        chk("R7 write during sleep ignored", d, model[8'hff]);
    endtask

    initial begin
        rst_n_l = 1'b0; rst_n_r = 1'b0;
        oe_n_l = 1'b0; oe_n_r = 1'b0; sleep_l = 1'b0; sleep_r = 1'b0;
        pipe_l = 1'b0; pipe_r = 1'b0;
        idle(0); idle(1);
        repeat (3) @(posedge clk_l);
        #2;
        t_reset();
        rst_n_l = 1'b1; rst_n_r = 1'b1;
        repeat (2) @(posedge clk_l);
        #1;
        t_full();
        t_partial();
        t_cross();
        t_pipe();
        t_desel();
        t_oe_sleep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule